// File: doc/BRIEF.md
# ADC Conversion Result and Flag Controller

This block is the register-side back end of an eight-channel, 10-bit analog-to-digital converter. Each finished conversion arrives as a beat on a valid/ready stream, with a channel index and a 10-bit sample. The block stores the sample in that channel's result register and in a shared most-recent-result register. It then updates a set of status flags: a per-channel conversion-done flag, a global ready flag, a per-channel overrun flag and a global overrun flag. Software or a DMA engine reads the results through a simple synchronous read port. Reads clear flags as a side effect, so no write is needed to acknowledge data.

The global ready flag issues a one-cycle request toward an external DMA channel each time it rises. An interrupt line is formed from the status flags and a mask register. That mask is changed through separate set and clear write addresses.

The conversion stream never applies back-pressure while the block is out of reset. `conv_ready` is low only while `rst` is high. A beat is taken only in a cycle where both `conv_valid` and `conv_ready` are high. The producer may hold `conv_valid` high for back-to-back beats, and each accepted beat counts as a separate conversion.

Top module: `adc_result_ctrl`

## Requirements
- R1: An accepted beat with channel c and sample v makes word c (0..7) and word 8 both read v, zero-extended to 32 bits, from the next cycle on.
- R2: An accepted beat for channel c sets status bit c (done flag) and status bit 16 (global ready).
- R3: Reading word c clears status bit c only.
- R4: Reading word 8 clears status bit 16 and the done bit of the channel most recently accepted.
- R5: A beat for channel c that arrives while status bit c is set sets status bit 8+c (channel overrun).
- R6: Any beat that arrives while status bit 16 is set sets status bit 17 (global overrun).
- R7: Reading word 9 (status) returns the flags and clears bits 8..17 except bit 16, which it leaves unchanged. Bits 0..7 are also unchanged by this read.
- R8: `dma_req` is high for exactly the first cycle in which status bit 16 is set after being clear.
- R9: Writing word 10 sets the mask bits given by the data, and writing word 11 clears them. Word 12 reads the 18-bit mask. `irq` is high when any status bit is set whose mask bit is also set.
- R10: When a beat sets a flag in the same cycle as a read that would clear that flag, the flag stays set.
- R11: While `rst` is high, every register and flag clears, `conv_ready` is low and beats are ignored.
- R12: Reads of words 13..31 return zero. Writes to any word other than 10 and 11 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | Conversion beat present |
| conv_ready | output | 1 | Beat accepted this cycle if valid |
| conv_chan | input | 3 | Channel index of the beat |
| conv_data | input | 10 | Converted sample |
| rd_en | input | 1 | Read strobe; side effects occur at the clock edge |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Read data for the current address (combinational) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 32 | Write data |
| dma_req | output | 1 | One-cycle transfer request |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. These include a beat landing on a channel in the cycle its result word is read, a beat arriving while the most-recent word is read, and an overrun being set while the status word is read. The directed part of the bench places each of these in a single step. A long pseudo-random phase then drives beats, reads over the full address range and mask writes together in every cycle. A bench-side flag model predicts every read, every `irq` level and every `dma_req` pulse.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CHAN,
    SEL_LAST,
    SEL_STAT,
    SEL_MASK
  } rd_sel_e;
endpackage

// File: rtl/adc_chan_slot.sv
module adc_chan_slot #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [DW-1:0] din,
  input  logic          clr_done,
  input  logic          clr_ovr,
  output logic [DW-1:0] data,
  output logic          done,
  output logic          ovr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      done <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (hit) data <= din;
      if (hit) done <= 1'b1;
      else if (clr_done) done <= 1'b0;
      if (hit && done) ovr <= 1'b1;
      else if (clr_ovr) ovr <= 1'b0;
    end
  end

  assert_data_R1: assert property (@(posedge clk) disable iff (rst)
    hit |=> data == $past(din));
  assert_done_set_R2: assert property (@(posedge clk) disable iff (rst)
    hit |=> done);
  assert_done_clr_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_done && !hit) |=> !done);
  assert_ovr_set_R5: assert property (@(posedge clk) disable iff (rst)
    (hit && done) |=> ovr);
  assert_ovr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (hit && done && clr_ovr) |=> ovr);
endmodule

// File: rtl/adc_global_flags.sv
module adc_global_flags #(
  parameter int DW  = 10,
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hit,
  input  logic [CHW-1:0] chan,
  input  logic [DW-1:0]  din,
  input  logic           clr_rdy,
  input  logic           clr_govr,
  output logic [DW-1:0]  last_data,
  output logic [CHW-1:0] last_chan,
  output logic           rdy,
  output logic           govr,
  output logic           dma_req
);
  logic rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_data <= '0;
      last_chan <= '0;
      rdy       <= 1'b0;
      govr      <= 1'b0;
      rdy_q     <= 1'b0;
    end else begin
      rdy_q <= rdy;
      if (hit) begin
        last_data <= din;
        last_chan <= chan;
      end
      if (hit) rdy <= 1'b1;
      else if (clr_rdy) rdy <= 1'b0;
      if (hit && rdy) govr <= 1'b1;
      else if (clr_govr) govr <= 1'b0;
    end
  end

  assign dma_req = rdy && !rdy_q;

  assert_rdy_set_R2: assert property (@(posedge clk) disable iff (rst)
    hit |=> rdy);
  assert_rdy_clr_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_rdy && !hit) |=> !rdy);
  assert_govr_set_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && rdy) |=> govr);
  assert_dma_single_R8: assert property (@(posedge clk) disable iff (rst)
    dma_req |=> !dma_req);
  assert_dma_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
    (!rdy && hit) |=> dma_req);
endmodule

// File: rtl/adc_irq_mask.sv
module adc_irq_mask #(
  parameter int SW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [SW-1:0] bits,
  input  logic [SW-1:0] status,
  output logic [SW-1:0] mask,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else if (set_en) mask <= mask | bits;
    else if (clr_en) mask <= mask & ~bits;
  end

  assign irq = |(status & mask);

  assert_mask_set_R9: assert property (@(posedge clk) disable iff (rst)
    set_en |=> (mask & $past(bits)) == $past(bits));
  assert_mask_clr_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en) |=> (mask & $past(bits)) == '0);
endmodule

// File: rtl/adc_result_ctrl.sv
module adc_result_ctrl #(
  parameter int NCH  = 8,
  parameter int DW   = 10,
  parameter int AW   = 5,
  parameter int BUSW = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     conv_valid,
  output logic                     conv_ready,
  input  logic [$clog2(NCH)-1:0]   conv_chan,
  input  logic [DW-1:0]            conv_data,
  input  logic                     rd_en,
  input  logic [AW-1:0]            rd_addr,
  output logic [BUSW-1:0]          rd_data,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [BUSW-1:0]          wr_data,
  output logic                     dma_req,
  output logic                     irq
);
  import adc_res_pkg::*;

  localparam int CHW = $clog2(NCH);
  localparam int SW  = 2 * NCH + 2;
  localparam logic [AW-1:0] A_LAST = AW'(NCH);
  localparam logic [AW-1:0] A_STAT = AW'(NCH + 1);
  localparam logic [AW-1:0] A_MSET = AW'(NCH + 2);
  localparam logic [AW-1:0] A_MCLR = AW'(NCH + 3);
  localparam logic [AW-1:0] A_MASK = AW'(NCH + 4);

  logic            take;
  logic [NCH-1:0]  done_v, ovr_v;
  logic [DW-1:0]   chan_data [NCH];
  logic [DW-1:0]   last_data;
  logic [CHW-1:0]  last_chan;
  logic            rdy, govr;
  logic [SW-1:0]   status, mask;
  rd_sel_e         sel;
  logic            rd_last, rd_stat;

  assign conv_ready = !rst;
  assign take       = conv_valid && conv_ready;

  always_comb begin
    if (rd_addr < A_LAST)       sel = SEL_CHAN;
    else if (rd_addr == A_LAST) sel = SEL_LAST;
    else if (rd_addr == A_STAT) sel = SEL_STAT;
    else if (rd_addr == A_MASK) sel = SEL_MASK;
    else                        sel = SEL_NONE;
  end

  assign rd_last = rd_en && (sel == SEL_LAST);
  assign rd_stat = rd_en && (sel == SEL_STAT);

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic hit_i, clr_i;
    assign hit_i = take && (conv_chan == CHW'(i));
    assign clr_i = (rd_en && sel == SEL_CHAN && rd_addr == AW'(i)) ||
                   (rd_last && last_chan == CHW'(i));
    adc_chan_slot #(.DW(DW)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit_i),
      .din     (conv_data),
      .clr_done(clr_i),
      .clr_ovr (rd_stat),
      .data    (chan_data[i]),
      .done    (done_v[i]),
      .ovr     (ovr_v[i])
    );
  end

  adc_global_flags #(.DW(DW), .CHW(CHW)) u_glob (
    .clk      (clk),
    .rst      (rst),
    .hit      (take),
    .chan     (conv_chan),
    .din      (conv_data),
    .clr_rdy  (rd_last),
    .clr_govr (rd_stat),
    .last_data(last_data),
    .last_chan(last_chan),
    .rdy      (rdy),
    .govr     (govr),
    .dma_req  (dma_req)
  );

  assign status = {govr, rdy, ovr_v, done_v};

  adc_irq_mask #(.SW(SW)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .set_en(wr_en && wr_addr == A_MSET),
    .clr_en(wr_en && wr_addr == A_MCLR),
    .bits  (wr_data[SW-1:0]),
    .status(status),
    .mask  (mask),
    .irq   (irq)
  );

  always_comb begin
    rd_data = '0;
    case (sel)
      SEL_CHAN: rd_data = BUSW'(chan_data[rd_addr[CHW-1:0]]);
      SEL_LAST: rd_data = BUSW'(last_data);
      SEL_STAT: rd_data = BUSW'(status);
      SEL_MASK: rd_data = BUSW'(mask);
      default:  rd_data = '0;
    endcase
  end

  assert_ready_R11: assert property (@(posedge clk) disable iff (rst)
    conv_ready);
  assert_last_chan_R4: assert property (@(posedge clk) disable iff (rst)
    take |=> last_chan == $past(conv_chan));
  assert_stat_keeps_done_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !take && !rd_last) |=> done_v == $past(done_v) && rdy == $past(rdy));
  assert_hold_on_collide_R10: assert property (@(posedge clk) disable iff (rst)
    (take && rd_last) |=> rdy);
endmodule

// File: tb/test_adc_result_ctrl.sv
`timescale 1ns/1ps
module test_adc_result_ctrl;
  localparam int NCH = 8;
  localparam int SW  = 18;

  logic        clk = 1'b0;
  logic        rst;
  logic        conv_valid, conv_ready;
  logic [2:0]  conv_chan;
  logic [9:0]  conv_data;
  logic        rd_en, wr_en;
  logic [4:0]  rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;
  logic        dma_req, irq;

  adc_result_ctrl i_adc_result_ctrl (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_ready(conv_ready),
    .conv_chan(conv_chan), .conv_data(conv_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dma_req(dma_req), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int nvec = 0;
  int nbad = 0;
  bit finished = 0;

  logic [9:0]    m_data [NCH];
  logic [9:0]    m_last;
  logic [2:0]    m_lch;
  logic [NCH-1:0] m_done, m_ovr;
  logic          m_rdy, m_govr;
  logic [SW-1:0] m_mask;

  function automatic logic [SW-1:0] m_status();
    return {m_govr, m_rdy, m_ovr, m_done};
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] a);
    if (a < 5'd8)        return {22'd0, m_data[a[2:0]]};
    else if (a == 5'd8)  return {22'd0, m_last};
    else if (a == 5'd9)  return {14'd0, m_status()};
    else if (a == 5'd12) return {14'd0, m_mask};
    else                 return 32'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string rtag(input logic [4:0] a);
    if (a < 5'd8)        return "R1/R3 channel read";
    else if (a == 5'd8)  return "R1/R4 last read";
    else if (a == 5'd9)  return "R7 status read";
    else if (a == 5'd12) return "R9 mask read";
    else                 return "R12 unmapped read";
  endfunction

  task automatic step(input bit cv, input logic [2:0] ch, input logic [9:0] v,
                      input bit re, input logic [4:0] ra,
                      input bit we, input logic [4:0] wa, input logic [31:0] wd);
    logic old_rdy;
    logic [NCH-1:0] old_done;
    logic [2:0] old_lch;
    conv_valid = cv; conv_chan = ch; conv_data = v;
    rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
    #1;
    if (re) chk(rtag(ra), rd_data, m_read(ra));
    @(posedge clk);
    old_rdy = m_rdy; old_done = m_done; old_lch = m_lch;
    if (re && ra < 5'd8) m_done[ra[2:0]] = 1'b0;
    if (re && ra == 5'd8) begin m_rdy = 1'b0; m_done[old_lch] = 1'b0; end
    if (re && ra == 5'd9) begin m_ovr = '0; m_govr = 1'b0; end
    if (we && wa == 5'd10) m_mask = m_mask | wd[SW-1:0];
    if (we && wa == 5'd11) m_mask = m_mask & ~wd[SW-1:0];
    if (cv) begin
      m_data[ch] = v; m_last = v; m_lch = ch;
      if (old_done[ch]) m_ovr[ch] = 1'b1;
      if (old_rdy) m_govr = 1'b1;
      m_done[ch] = 1'b1; m_rdy = 1'b1;
    end
    @(negedge clk);
    chk("R8 dma_req", {31'd0, dma_req}, {31'd0, m_rdy && !old_rdy});
    chk("R9 irq", {31'd0, irq}, {31'd0, |(m_status() & m_mask)});
    conv_valid = 0; rd_en = 0; wr_en = 0;
  endtask

  task automatic idle_read(input logic [4:0] a);
    step(0, 3'd0, 10'd0, 1, a, 0, 5'd0, 32'd0);
  endtask

  task automatic conv(input logic [2:0] ch, input logic [9:0] v);
    step(1, ch, v, 0, 5'd0, 0, 5'd0, 32'd0);
  endtask

  task automatic reset_all();
    rst = 1'b1;
    conv_valid = 1'b1; conv_chan = 3'd5; conv_data = 10'h155;
    rd_en = 0; wr_en = 1; wr_addr = 5'd10; wr_data = '1; rd_addr = 5'd0;
    repeat (3) @(negedge clk);
    chk("R11 conv_ready low in reset", {31'd0, conv_ready}, 32'd0);
    rst = 1'b0; conv_valid = 0; wr_en = 0;
    for (int i = 0; i < NCH; i++) m_data[i] = '0;
    m_last = '0; m_lch = '0; m_done = '0; m_ovr = '0;
    m_rdy = 0; m_govr = 0; m_mask = '0;
    @(negedge clk);
    chk("R11 conv_ready after reset", {31'd0, conv_ready}, 32'd1);
    chk("R11 irq after reset", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    @(negedge clk);
    reset_all();
    for (int a = 0; a < 32; a++) idle_read(a[4:0]);     // R11: all zero
    step(0, 0, 0, 0, 0, 1, 5'd10, 32'h3FFFF);           // R9: full mask
    idle_read(5'd12);
    // R1/R2/R3: each channel, distinct sample
    for (int c = 0; c < NCH; c++) begin
      conv(c[2:0], 10'((c * 97 + 5) & 10'h3FF));
      idle_read(5'd9);
      idle_read(5'd8);
      idle_read(c[4:0]);
      idle_read(5'd9);
    end
    // R5/R6/R7: double conversions produce overruns
    for (int c = 0; c < NCH; c++) begin
      conv(c[2:0], 10'(c * 3));
      conv(c[2:0], 10'(1023 - c));
      idle_read(5'd9);
      idle_read(5'd9);
      idle_read(c[4:0]);
      idle_read(5'd8);
    end
    // R4: last read clears done of last channel only
    conv(3'd2, 10'h0AA); conv(3'd6, 10'h155);
    idle_read(5'd8); idle_read(5'd9);
    idle_read(5'd2); idle_read(5'd9);
    // R10: collisions
    conv(3'd3, 10'h011);
    step(1, 3'd3, 10'h022, 1, 5'd3, 0, 0, 0);           // read ch3 + new ch3
    idle_read(5'd9);
    step(1, 3'd4, 10'h033, 1, 5'd8, 0, 0, 0);           // last read + new beat
    idle_read(5'd9);
    step(1, 3'd4, 10'h044, 1, 5'd9, 0, 0, 0);           // status read + overrun
    idle_read(5'd9);
    step(1, 3'd1, 10'h3FF, 1, 5'd8, 0, 0, 0);           // last=ch4 cleared, ch1 set
    idle_read(5'd9);
    // R9: mask clear, R12: stray write
    step(0, 0, 0, 0, 0, 1, 5'd11, 32'h0FFFF);
    idle_read(5'd12);
    step(0, 0, 0, 0, 0, 1, 5'd12, 32'hFFFFFFFF);
    step(0, 0, 0, 0, 0, 1, 5'd3, 32'h12345678);
    idle_read(5'd12); idle_read(5'd3);
    step(0, 0, 0, 0, 0, 1, 5'd11, 32'h3FFFF);
    idle_read(5'd9);
    // mixed pseudo-random sweep
    lf = 32'hACE1_2468;
    for (int n = 0; n < 4000; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step(lf[0] & lf[3], lf[6:4], lf[16:7], lf[1] | lf[2], lf[21:17],
           (lf[25:22] == 4'd0), lf[26] ? 5'd10 : 5'd11,
           {14'd0, lf[31:27], lf[12:0]});
    end
    reset_all();
    idle_read(5'd9); idle_read(5'd8); idle_read(5'd12);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule